// File: doc/BRIEF.md
# Host Parallel Memory Access Port

This block is a slave port through which an external host reads and writes a processor's internal memories while the processor keeps running. The host shares one 16-bit bus for addresses and data. It uses a select line and three strobes: address latch, read and write. An address latch loads a 16-bit control word. Its top bit picks the memory: 1 for the 16-bit data memory, 0 for the 24-bit program memory. The remaining 15 bits are the start address. Each later read or write strobe moves one bus word. The block advances the address by itself, so a host can stream a block of words after a single latch.

The host strobes are asynchronous. They pass through a synchronizer into the core clock, and the block acts on their leading edges. Each access to memory takes exactly one core memory cycle. A program word is 24 bits, so it moves as two bus transfers: the upper 16 bits first, then the low 8 bits. An active-low acknowledge tells the host when the port is ready for its next step.

The core has its own write and read port to the same control word. This lets firmware set the start address while the host only drives strobes.

Top module: `hpa_port`

## Requirements
- R1: Select with address latch loads the 16-bit bus value into the control word, visible on `creg_rdata`. Bit 15 set means data memory and bit 15 clear means program memory. Bits 14:0 are the address.
- R2: A data-memory read returns the 16-bit word at the current address on `had_o`. `had_oe` is high only while select and read are both asserted at the pins.
- R3: A data-memory write stores the bus value as one memory write, with `mem_wdata[23:16]` zero.
- R4: The address advances by one after each data-memory access and after the second half of each program-memory word, but not after a first half. It wraps from 0x7FFF to 0. The memory-type bit is unchanged by the step.
- R5: A program-memory read returns word bits 23:8 on the first transfer and {8'h00, bits 7:0} on the second.
- R6: A program-memory write holds the first transfer. The second transfer commits {first[15:0], second[7:0]} in one memory write, and bits 15:8 of the second transfer are ignored.
- R7: `hack_n` is low after reset and while idle, high while an operation is in progress, and low again when it completes.
- R8: A memory request lasts exactly one cycle. One program word costs one memory request in each direction, and a data word costs one.
- R9: An address latch or a core write to the control word between the two halves of a program-memory read drops the pending second half. The next transfer is a first half at the new address.
- R10: `creg_we` loads `creg_wdata` into the control word. If it coincides with a host address latch, the host value wins.
- R11: A strobe held asserted for many cycles performs exactly one operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsel_n | input | 1 | Host port select, active low |
| hlatch | input | 1 | Host address latch strobe, active high |
| hrd_n | input | 1 | Host read strobe, active low |
| hwr_n | input | 1 | Host write strobe, active low |
| had_i | input | 16 | Address/data bus, host to port |
| had_o | output | 16 | Address/data bus, port to host |
| had_oe | output | 1 | Bus drive enable for `had_o` |
| hack_n | output | 1 | Ready acknowledge, low when idle |
| creg_we | input | 1 | Core write strobe for the control word |
| creg_wdata | input | 16 | Core write value for the control word |
| creg_rdata | output | 16 | Control word as seen by the core |
| mem_req | output | 1 | One-cycle memory access request |
| mem_we | output | 1 | Request is a write |
| mem_dm | output | 1 | 1 selects data memory, 0 program memory |
| mem_addr | output | 15 | Memory address |
| mem_wdata | output | 24 | Memory write word |
| mem_rdata | input | 24 | Memory read word, valid the cycle after a request |

## Verification
The bench builds the port with its default widths: a 16-bit bus, a 24-bit program word and a two-stage synchronizer. With these widths a latch of 0xFFFF reaches the top address, so the wrap back to zero can be checked. The 8-bit low half of a program word is also exercised with a nonzero upper byte on the bus, so the ignored bits are tested. The two-stage depth fixes the cycle in which a latch edge takes effect. This lets the bench place a core write in exactly that cycle and check the host-wins rule.

// File: rtl/hpa_pkg.sv
package hpa_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_LAT  = 2'd1,
    XS_REQ  = 2'd2,
    XS_CAP  = 2'd3
  } xfer_st_t;
endpackage

// File: rtl/hpa_sync.sv
module hpa_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o
);
  logic [STAGES-1:0][W-1:0] stg;
  logic [W-1:0]             prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg  <= '0;
      prev <= '0;
    end else begin
      stg  <= {stg[STAGES-2:0], async_i};
      prev <= stg[STAGES-1];
    end
  end

  assign lvl_o  = stg[STAGES-1];
  assign rise_o = stg[STAGES-1] & ~prev;
endmodule

// File: rtl/hpa_creg.sv
module hpa_creg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_ld,
  input  logic [DW-1:0] host_val,
  input  logic          core_we,
  input  logic [DW-1:0] core_val,
  input  logic          inc,
  output logic [DW-1:0] creg
);
  localparam int AW = DW - 1;

  function automatic logic [AW-1:0] addr_next(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       creg <= '0;
    else if (host_ld) creg <= host_val;
    else if (core_we) creg <= core_val;
    else if (inc)     creg <= {creg[DW-1], addr_next(creg[AW-1:0])};
  end
endmodule

// File: rtl/hpa_xfer.sv
module hpa_xfer
  import hpa_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_ev,
  input  logic          wr_ev,
  input  logic          lat_ev,
  input  logic          core_we,
  input  logic          dm_sel,
  input  logic [DW-1:0] bus_in,
  input  logic [PW-1:0] mem_rdata,
  output logic          busy,
  output logic          lat_take,
  output logic          inc,
  output logic          mem_req,
  output logic          mem_we,
  output logic [PW-1:0] mem_wdata,
  output logic [DW-1:0] rdat
);
  localparam int LW = PW - DW;

  function automatic logic [DW-1:0] hi_part(input logic [PW-1:0] w);
    return w[PW-1:LW];
  endfunction
  function automatic logic [DW-1:0] lo_pad(input logic [LW-1:0] b);
    return {{(DW-LW){1'b0}}, b};
  endfunction
  function automatic logic [PW-1:0] pm_join(input logic [DW-1:0] hi, input logic [DW-1:0] lo);
    return {hi, lo[LW-1:0]};
  endfunction

  xfer_st_t      st;
  logic          is_wr, is_dm, half;
  logic [DW-1:0] wbuf, pmhi;
  logic [LW-1:0] pmrd;
  logic          touch_mem, abort;

  assign lat_take  = (st == XS_IDLE) && lat_ev;
  assign abort     = lat_take || core_we;
  assign busy      = (st != XS_IDLE);
  assign touch_mem = is_dm || (is_wr ? half : !half);
  assign mem_req   = (st == XS_REQ) && touch_mem;
  assign mem_we    = is_wr;
  assign mem_wdata = is_dm ? {{LW{1'b0}}, wbuf} : pm_join(pmhi, wbuf);
  assign inc       = (st == XS_CAP) && (is_dm || half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= XS_IDLE;
      is_wr <= 1'b0;
      is_dm <= 1'b0;
      half  <= 1'b0;
      wbuf  <= '0;
      pmhi  <= '0;
      pmrd  <= '0;
      rdat  <= '0;
    end else begin
      case (st)
        XS_IDLE: begin
          if (lat_ev) begin
            st <= XS_LAT;
          end else if (rd_ev || wr_ev) begin
            st    <= XS_REQ;
            is_wr <= wr_ev;
            is_dm <= dm_sel;
            wbuf  <= bus_in;
          end
        end
        XS_LAT: st <= XS_IDLE;
        XS_REQ: st <= XS_CAP;
        XS_CAP: begin
          st <= XS_IDLE;
          if (!is_wr) begin
            if (is_dm) begin
              rdat <= mem_rdata[DW-1:0];
            end else if (!half) begin
              rdat <= hi_part(mem_rdata);
              pmrd <= mem_rdata[LW-1:0];
            end else begin
              rdat <= lo_pad(pmrd);
            end
          end else if (!is_dm && !half) begin
            pmhi <= wbuf;
          end
          if (!is_dm) half <= !half;
        end
        default: st <= XS_IDLE;
      endcase
      if (abort) half <= 1'b0;
    end
  end
endmodule

// File: rtl/hpa_port.sv
module hpa_port #(
  parameter int DW          = 16,
  parameter int PW          = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsel_n,
  input  logic          hlatch,
  input  logic          hrd_n,
  input  logic          hwr_n,
  input  logic [DW-1:0] had_i,
  output logic [DW-1:0] had_o,
  output logic          had_oe,
  output logic          hack_n,
  input  logic          creg_we,
  input  logic [DW-1:0] creg_wdata,
  output logic [DW-1:0] creg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_dm,
  output logic [DW-2:0] mem_addr,
  output logic [PW-1:0] mem_wdata,
  input  logic [PW-1:0] mem_rdata
);
  localparam int AW = DW - 1;

  logic [2:0] strobe_raw, strobe_lvl, strobe_rise;
  logic       lat_ev, rd_ev, wr_ev;
  logic       lat_take, inc, busy;
  logic [DW-1:0] creg;

  assign strobe_raw = {!hsel_n && hlatch, !hsel_n && !hrd_n, !hsel_n && !hwr_n};

  hpa_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(strobe_raw),
    .lvl_o(strobe_lvl), .rise_o(strobe_rise)
  );

  assign lat_ev = strobe_rise[2];
  assign rd_ev  = strobe_rise[1];
  assign wr_ev  = strobe_rise[0];

  hpa_creg #(.DW(DW)) u_creg (
    .clk(clk), .rst_n(rst_n), .host_ld(lat_take), .host_val(had_i),
    .core_we(creg_we), .core_val(creg_wdata), .inc(inc), .creg(creg)
  );

  hpa_xfer #(.DW(DW), .PW(PW)) u_xfer (
    .clk(clk), .rst_n(rst_n), .rd_ev(rd_ev), .wr_ev(wr_ev), .lat_ev(lat_ev),
    .core_we(creg_we), .dm_sel(creg[DW-1]), .bus_in(had_i), .mem_rdata(mem_rdata),
    .busy(busy), .lat_take(lat_take), .inc(inc), .mem_req(mem_req),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .rdat(had_o)
  );

  assign had_oe     = !hsel_n && !hrd_n;
  assign hack_n     = busy;
  assign creg_rdata = creg;
  assign mem_dm     = creg[DW-1];
  assign mem_addr   = creg[AW-1:0];
endmodule

// File: rtl/hpa_port_chk.sv
module hpa_port_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lat_take,
  input logic          inc,
  input logic          creg_we,
  input logic [DW-1:0] had_i,
  input logic [DW-1:0] creg_wdata,
  input logic [DW-1:0] creg_rdata,
  input logic          mem_req,
  input logic          hack_n
);
  localparam int AW = DW - 1;

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    lat_take |=> creg_rdata == $past(had_i));  // R1
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !lat_take && !creg_we) |=> (creg_rdata[AW-1:0] == AW'($past(creg_rdata[AW-1:0]) + 1'b1)) && $stable(creg_rdata[DW-1]));  // R4
  AST_BUSY_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> hack_n);  // R7
  AST_ONE_MEM_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);  // R8
  AST_CORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (creg_we && !lat_take) |=> creg_rdata == $past(creg_wdata));  // R10
endmodule

bind hpa_port hpa_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lat_take(lat_take), .inc(inc), .creg_we(creg_we),
  .had_i(had_i), .creg_wdata(creg_wdata), .creg_rdata(creg_rdata),
  .mem_req(mem_req), .hack_n(hack_n)
);

// File: tb/sim_hpa_port.sv
module sim_hpa_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsel_n = 1'b1, hlatch = 1'b0, hrd_n = 1'b1, hwr_n = 1'b1;
  logic [15:0] had_i = '0;
  logic [15:0] had_o;
  logic        had_oe, hack_n;
  logic        creg_we = 1'b0;
  logic [15:0] creg_wdata = '0;
  logic [15:0] creg_rdata;
  logic        mem_req, mem_we, mem_dm;
  logic [14:0] mem_addr;
  logic [23:0] mem_wdata;
  logic [23:0] mem_rdata = '0;

  always #5 clk = ~clk;

  hpa_port u0 (.*);

  int n_chk = 0, n_bad = 0, n_req = 0;
  bit finished = 1'b0;
  logic [23:0] dmem [int];
  logic [23:0] pmem [int];
  logic [40:0] exp_wr [$];  // {dm, addr[15:0], data[23:0]}

  function automatic logic [23:0] dm_pat(input int a);
    return {8'h00, 16'(a * 5) ^ 16'hA5C3};
  endfunction
  function automatic logic [23:0] pm_pat(input int a);
    return {8'(a) ^ 8'h5A, 16'(a * 7) + 16'h1357};
  endfunction
  function automatic logic [23:0] mem_at(input bit dm, input int a);
    if (dm) return dmem.exists(a) ? dmem[a] : dm_pat(a);
    return pmem.exists(a) ? pmem[a] : pm_pat(a);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model and write-side monitor of the scoreboard
  always @(posedge clk) begin
    if (mem_req) begin
      n_req++;
      if (mem_we) begin
        if (exp_wr.size() == 0) begin
          chk(1'b0, "R3/R6 unexpected write", {mem_dm, mem_addr, 16'h0}, 32'h0);
        end else begin
          logic [40:0] e;
          e = exp_wr.pop_front();
          chk({mem_dm, mem_addr, mem_wdata} == {e[40], e[38:24], e[23:0]}, "R3/R6 write",
              {mem_dm, mem_addr[6:0], mem_wdata}, {e[40], e[30:24], e[23:0]});
        end
        if (mem_dm) dmem[int'(mem_addr)] = mem_wdata; else pmem[int'(mem_addr)] = mem_wdata;
      end else begin
        mem_rdata <= mem_at(mem_dm, int'(mem_addr));
      end
    end
  end

  task automatic host_step(input int kind, input logic [15:0] val,
                           output logic [15:0] got, output bit busy_seen, output bit oe_seen);
    @(negedge clk);
    had_i = val; hsel_n = 1'b0;
    hlatch = (kind == 0); hrd_n = !(kind == 1); hwr_n = !(kind == 2);
    busy_seen = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (hack_n) busy_seen = 1'b1;
      else if (busy_seen) break;
    end
    got = had_o; oe_seen = had_oe;
    @(negedge clk);
    hsel_n = 1'b1; hlatch = 1'b0; hrd_n = 1'b1; hwr_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic latch(input logic [15:0] v);
    logic [15:0] g; bit b, o;
    host_step(0, v, g, b, o);
  endtask
  task automatic rd(output logic [15:0] g);
    bit b, o;
    host_step(1, 16'h0, g, b, o);
  endtask
  task automatic wr_dm(input logic [15:0] v);
    logic [15:0] g; bit b, o;
    exp_wr.push_back({1'b1, creg_rdata, 8'h00, v});
    host_step(2, v, g, b, o);
  endtask
  task automatic core_wr(input logic [15:0] v);
    @(negedge clk); creg_we = 1'b1; creg_wdata = v;
    @(negedge clk); creg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] g, g2, hi;
    bit b, o;
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hack_n == 1'b0, "R7 reset ack", hack_n, 0);
    chk(creg_rdata == 16'h0 && !mem_req && !had_oe, "R1 reset state", creg_rdata, 0);

    // R1 latch data-memory address
    host_step(0, 16'h8010, g, b, o);
    chk(creg_rdata == 16'h8010, "R1 latch", creg_rdata, 16'h8010);

    // R2 data read, R7 busy then ready, R4 step
    host_step(1, 16'h0, g, b, o);
    chk(g == dm_pat(16)[15:0], "R2 dm read", g, dm_pat(16)[15:0]);
    chk(o == 1'b1, "R2 oe while reading", o, 1);
    chk(b && !hack_n, "R7 busy then ready", {b, hack_n}, 2'b10);
    chk(!had_oe, "R2 oe released", had_oe, 0);
    chk(creg_rdata == 16'h8011, "R4 dm step", creg_rdata, 16'h8011);

    // R3 data write then read back
    r0 = n_req;
    wr_dm(16'h1234);
    chk(n_req - r0 == 1, "R8 dm write one request", n_req - r0, 1);
    latch(16'h8011);
    rd(g);
    chk(g == 16'h1234, "R3 dm readback", g, 16'h1234);

    // R5 program read halves
    latch(16'h0020);
    r0 = n_req;
    rd(g);
    chk(g == pm_pat(32)[23:8], "R5 pm first half", g, pm_pat(32)[23:8]);
    chk(creg_rdata == 16'h0020, "R4 no step after first half", creg_rdata, 16'h0020);
    rd(g);
    chk(g == {8'h00, pm_pat(32)[7:0]}, "R5 pm second half", g, {8'h00, pm_pat(32)[7:0]});
    chk(n_req - r0 == 1, "R8 pm read one request", n_req - r0, 1);
    chk(creg_rdata == 16'h0021, "R4 pm step", creg_rdata, 16'h0021);

    // R6 program write, upper byte of second half ignored
    r0 = n_req;
    host_step(2, 16'hBEEF, g, b, o);
    chk(n_req == r0, "R8 pm first write no request", n_req - r0, 0);
    exp_wr.push_back({1'b0, 16'h0021, 24'hBEEF77});
    host_step(2, 16'hFF77, g, b, o);
    chk(n_req - r0 == 1, "R6 pm write one request", n_req - r0, 1);
    chk(creg_rdata == 16'h0022, "R4 pm write step", creg_rdata, 16'h0022);
    latch(16'h0021);
    rd(g); rd(g2);
    chk({g, g2} == 32'hBEEF0077, "R6 pm readback", {g, g2}, 32'hBEEF0077);

    // R9 relatch between halves
    latch(16'h0030);
    rd(g);
    latch(16'h0040);
    rd(g);
    chk(g == pm_pat(64)[23:8], "R9 latch drops second half", g, pm_pat(64)[23:8]);
    chk(creg_rdata == 16'h0040, "R9 first half at new address", creg_rdata, 16'h0040);

    // R9/R10 core write between halves
    core_wr(16'h0050);
    chk(creg_rdata == 16'h0050, "R10 core write", creg_rdata, 16'h0050);
    rd(g);
    chk(g == pm_pat(80)[23:8], "R9 core write drops second half", g, pm_pat(80)[23:8]);

    // R4 wrap
    latch(16'hFFFF);
    rd(g);
    chk(g == dm_pat(32767)[15:0], "R4 top address read", g, dm_pat(32767)[15:0]);
    chk(creg_rdata == 16'h8000, "R4 wrap", creg_rdata, 16'h8000);

    // R10 host latch wins over same-cycle core write
    @(negedge clk);
    had_i = 16'h8100; hsel_n = 1'b0; hlatch = 1'b1;
    @(negedge clk);
    @(negedge clk); creg_we = 1'b1; creg_wdata = 16'h0200;
    @(negedge clk); creg_we = 1'b0;
    repeat (4) @(negedge clk);
    hsel_n = 1'b1; hlatch = 1'b0;
    repeat (3) @(negedge clk);
    chk(creg_rdata == 16'h8100, "R10 host wins", creg_rdata, 16'h8100);

    // R11 held strobe performs one operation
    r0 = n_req;
    @(negedge clk);
    hsel_n = 1'b0; hrd_n = 1'b0;
    repeat (25) @(negedge clk);
    chk(n_req - r0 == 1, "R11 one request per strobe", n_req - r0, 1);
    chk(had_oe && had_o == dm_pat(256)[15:0], "R11 held data", had_o, dm_pat(256)[15:0]);
    chk(creg_rdata == 16'h8101, "R11 single step", creg_rdata, 16'h8101);
    hsel_n = 1'b1; hrd_n = 1'b1;
    repeat (3) @(negedge clk);

    chk(exp_wr.size() == 0, "R3/R6 all writes seen", exp_wr.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule